// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Sequencer

This block sits between a programmable clock source and its two output drivers: a reference output that can carry either the undivided master clock or a prescaled copy of it, and a main output. Two external control pins, together with four configuration bits, decide what the pins do. The first pin can act as a live frequency selector for the reference output, as an active-high disable for it, or as a device-wide power-down request. The second pin can act as an active-high disable for the main output, or as a power-down request. The block returns the tri-state enable for each output, the registered reference frequency select, a device shutdown signal and a flag that blocks register programming.

Every enable change is gated on the current level of the clock that the output carries, so an output switches to or from high impedance only while that clock is low. The reference select changes only while both candidate clocks are low. A power-down request must stay asserted for `PD_HOLD` consecutive cycles. Once it qualifies, both outputs are drained first, and shutdown is asserted only after both enables have dropped. After reset, and after every wake-up, both outputs stay off for `WARM_CYCLES` clocks while the source settles. All pins and clock levels are sampled synchronously to `clk`.

Top module: `oscout_pwr_ctl`

## Requirements
- R1: While `rst` is high and on the first sampled cycle after it, both enables and `shutdown_o` are 0. With no power-down request, the enables that the configuration allows rise on the (`WARM_CYCLES`+1)-th rising edge after `rst` falls, and not earlier.
- R2: With `cfg_pdn0_i`=1, `pin0_i`=1 is a power-down request whatever `cfg_en0_i` is. While the device is up, the reference output is enabled and `ref_sel_o` follows `cfg_sel0_i`, where 0 is the master clock and 1 is the prescaled clock.
- R3: With `cfg_pdn0_i`=0 and `cfg_en0_i`=1, `pin0_i`=1 disables the reference output and `pin0_i`=0 enables it. `ref_sel_o` follows `cfg_sel0_i`.
- R4: With `cfg_pdn0_i`=0, `cfg_en0_i`=0 and `cfg_sel0_i`=1, `pin0_i` drives `ref_sel_o` (0 = master, 1 = prescaled), and the reference output is always enabled.
- R5: With `cfg_pdn0_i`, `cfg_en0_i` and `cfg_sel0_i` all 0, `pin0_i`=1 is a power-down request, and the reference output stays disabled even while the device is up.
- R6: With `cfg_pdn1_i`=0, `pin1_i`=1 disables the main output. With `cfg_pdn1_i`=1, `pin1_i`=1 is a power-down request and the main output is enabled while the device is up. The power-down request is the OR of both pins' qualified requests.
- R7: An output enable changes only on a rising edge where the level of the clock that output carries was sampled low. While that level stays high, the enable holds its value.
- R8: `ref_sel_o` changes only on a rising edge where both `ref_master_i` and `ref_scaled_i` were sampled low.
- R9: A power-down request takes effect only after it has been seen on `PD_HOLD` consecutive rising edges. A shorter request leaves the outputs and `shutdown_o` unchanged.
- R10: Once a power-down takes effect, both enables fall first, each waiting for its clock to be low. `shutdown_o` rises on the edge after both are 0, and both enables stay 0 while it is high.
- R11: When the power-down request is withdrawn, `shutdown_o` falls on the second rising edge. The outputs then stay off for another `WARM_CYCLES` edges and re-enable on the edge after that.
- R12: `prog_inhibit_o` is 1 exactly while `shutdown_o` is 1.
- R13: A power-down request that qualifies on the same edge on which the start-up interval would end takes precedence. The outputs never enable, and `shutdown_o` rises on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (master clock domain) |
| rst | input | 1 | Synchronous active-high reset |
| ref_master_i | input | 1 | Sampled level of the undivided master clock |
| ref_scaled_i | input | 1 | Sampled level of the prescaled reference clock |
| main_lvl_i | input | 1 | Sampled level of the clock driven on the main output |
| pin0_i | input | 1 | First control pin (select, disable or power-down) |
| pin1_i | input | 1 | Second control pin (disable or power-down) |
| cfg_en0_i | input | 1 | Reference enable-mode bit |
| cfg_sel0_i | input | 1 | Reference select bit |
| cfg_pdn0_i | input | 1 | First pin power-down mode bit |
| cfg_pdn1_i | input | 1 | Second pin power-down mode bit |
| ref_oe_o | output | 1 | Tri-state enable of the reference output |
| ref_sel_o | output | 1 | Reference mux select (1 = prescaled) |
| main_oe_o | output | 1 | Tri-state enable of the main output |
| shutdown_o | output | 1 | Device shutdown |
| prog_inhibit_o | output | 1 | Register programming blocked |

## Verification
Two functions can land on the same edge: the power-down persistence filter can qualify a request on exactly the edge where the start-up counter expires. The bench provokes this by raising the second pin, configured as a power-down, exactly `PD_HOLD` edges before the end of the start-up interval. It then judges that the enables never rise and that shutdown follows one edge later. A second collision, a qualified power-down against an output whose clock is held high, is judged by confirming that shutdown waits until that enable has actually fallen.

// File: rtl/oscout_pwr_pkg.sv
package oscout_pwr_pkg;

    typedef enum logic [1:0] {
        P0_SELECT  = 2'd0,
        P0_DISABLE = 2'd1,
        P0_PDOWN   = 2'd2,
        P0_KILL    = 2'd3
    } pin0_role_e;

    typedef enum logic [1:0] {
        PS_WARM  = 2'd0,
        PS_RUN   = 2'd1,
        PS_DRAIN = 2'd2,
        PS_DOWN  = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic ref_want;
        logic main_want;
        logic sel_req;
        logic pd_req;
    } pin_req_t;

    function automatic pin0_role_e pin0_role(input logic en, input logic sel, input logic pdn);
        pin0_role_e r;
        if (pdn)
            r = P0_PDOWN;
        else if (en)
            r = P0_DISABLE;
        else if (sel)
            r = P0_SELECT;
        else
            r = P0_KILL;
        return r;
    endfunction

endpackage

// File: rtl/oscout_pin_decode.sv
module oscout_pin_decode
    import oscout_pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin0,
    input  logic     pin1,
    input  logic     cfg_en0,
    input  logic     cfg_sel0,
    input  logic     cfg_pdn0,
    input  logic     cfg_pdn1,
    input  logic     lvl_master,
    input  logic     lvl_scaled,
    output pin_req_t req,
    output logic     sel_q
);

    pin0_role_e role;
    logic       pd0;
    logic       pd1;

    always_comb begin
        role          = pin0_role(cfg_en0, cfg_sel0, cfg_pdn0);
        req.sel_req   = cfg_sel0;
        req.ref_want  = 1'b1;
        pd0           = 1'b0;
        unique case (role)
            P0_SELECT:  req.sel_req  = pin0;
            P0_DISABLE: req.ref_want = ~pin0;
            P0_PDOWN:   pd0          = pin0;
            P0_KILL: begin
                req.ref_want = 1'b0;
                pd0          = pin0;
            end
            default: req.ref_want = 1'b0;
        endcase
        pd1           = cfg_pdn1 & pin1;
        req.main_want = cfg_pdn1 | ~pin1;
        req.pd_req    = pd0 | pd1;
    end

    // Select moves only while both candidate clocks are low.
    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= 1'b0;
        else if (!lvl_master && !lvl_scaled)
            sel_q <= req.sel_req;
    end

    AST_SEL_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_q) |-> $past(!lvl_master && !lvl_scaled)) else $error("sel moved"); // R8

endmodule

// File: rtl/oscout_pd_filter.sv
module oscout_pd_filter #(
    parameter int PD_HOLD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    output logic pd_ok
);

    localparam int CW = $clog2(PD_HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(PD_HOLD);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!pd_req)
            cnt <= '0;
        else if (cnt != HOLD_V)
            cnt <= cnt + 1'b1;
    end

    assign pd_ok = (cnt == HOLD_V);

    AST_PD_PERSIST: assert property (@(posedge clk) disable iff (rst)
        pd_ok |-> $past(pd_req)) else $error("pd without request"); // R9

endmodule

// File: rtl/oscout_pwr_seq.sv
module oscout_pwr_seq
    import oscout_pwr_pkg::*;
#(
    parameter int WARM_CYCLES = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_ok,
    input  logic oe_any,
    output logic run_allow,
    output logic shutdown
);

    localparam int WW = $clog2(WARM_CYCLES + 1);
    localparam logic [WW-1:0] WARM_LAST = WW'(WARM_CYCLES - 1);

    pwr_state_e    state;
    logic [WW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_WARM;
            wcnt  <= '0;
        end else begin
            unique case (state)
                PS_WARM: begin
                    if (pd_ok)
                        state <= PS_DRAIN;
                    else if (wcnt == WARM_LAST)
                        state <= PS_RUN;
                    else
                        wcnt <= wcnt + 1'b1;
                end
                PS_RUN: if (pd_ok) state <= PS_DRAIN;
                PS_DRAIN: begin
                    if (!pd_ok)
                        state <= PS_RUN;
                    else if (!oe_any)
                        state <= PS_DOWN;
                end
                PS_DOWN: begin
                    if (!pd_ok) begin
                        state <= PS_WARM;
                        wcnt  <= '0;
                    end
                end
                default: state <= PS_WARM;
            endcase
        end
    end

    assign run_allow = (state == PS_RUN);
    assign shutdown  = (state == PS_DOWN);

    AST_WARM_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == PS_WARM) |-> !oe_any) else $error("output on in warm-up"); // R1
    AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> $past(!oe_any)) else $error("shutdown before drain"); // R10

endmodule

// File: rtl/oscout_oe_gate.sv
module oscout_oe_gate (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic lvl,
    output logic oe
);

    always_ff @(posedge clk) begin
        if (rst)
            oe <= 1'b0;
        else if (!lvl)
            oe <= want;
    end

    AST_OE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe) |-> !$past(lvl)) else $error("enable moved while high"); // R7

endmodule

// File: rtl/oscout_pwr_ctl.sv
module oscout_pwr_ctl
    import oscout_pwr_pkg::*;
#(
    parameter int WARM_CYCLES = 8000,
    parameter int PD_HOLD     = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_master_i,
    input  logic ref_scaled_i,
    input  logic main_lvl_i,
    input  logic pin0_i,
    input  logic pin1_i,
    input  logic cfg_en0_i,
    input  logic cfg_sel0_i,
    input  logic cfg_pdn0_i,
    input  logic cfg_pdn1_i,
    output logic ref_oe_o,
    output logic ref_sel_o,
    output logic main_oe_o,
    output logic shutdown_o,
    output logic prog_inhibit_o
);

    localparam int NOUT = 2;

    pin_req_t        req;
    logic            sel_q;
    logic            pd_ok;
    logic            run_allow;
    logic            shut;
    logic [NOUT-1:0] want;
    logic [NOUT-1:0] lvl;
    logic [NOUT-1:0] oe;

    oscout_pin_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .pin0       (pin0_i),
        .pin1       (pin1_i),
        .cfg_en0    (cfg_en0_i),
        .cfg_sel0   (cfg_sel0_i),
        .cfg_pdn0   (cfg_pdn0_i),
        .cfg_pdn1   (cfg_pdn1_i),
        .lvl_master (ref_master_i),
        .lvl_scaled (ref_scaled_i),
        .req        (req),
        .sel_q      (sel_q)
    );

    oscout_pd_filter #(.PD_HOLD(PD_HOLD)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .pd_req (req.pd_req),
        .pd_ok  (pd_ok)
    );

    oscout_pwr_seq #(.WARM_CYCLES(WARM_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pd_ok     (pd_ok),
        .oe_any    (|oe),
        .run_allow (run_allow),
        .shutdown  (shut)
    );

    // Index 0: reference output, index 1: main output.
    assign want[0] = run_allow & req.ref_want;
    assign want[1] = run_allow & req.main_want;
    assign lvl[0]  = sel_q ? ref_scaled_i : ref_master_i;
    assign lvl[1]  = main_lvl_i;

    for (genvar g = 0; g < NOUT; g++) begin : g_gate
        oscout_oe_gate u_gate (
            .clk  (clk),
            .rst  (rst),
            .want (want[g]),
            .lvl  (lvl[g]),
            .oe   (oe[g])
        );
    end

    assign ref_oe_o       = oe[0];
    assign main_oe_o      = oe[1];
    assign ref_sel_o      = sel_q;
    assign shutdown_o     = shut;
    assign prog_inhibit_o = shut;

    AST_SHUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        shutdown_o |-> (!ref_oe_o && !main_oe_o)) else $error("output on in shutdown"); // R10
    AST_INHIBIT_TRACK: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown_o) |-> prog_inhibit_o) else $error("inhibit missing"); // R12

endmodule

// File: tb/oscout_pwr_ctl_bench.sv
module oscout_pwr_ctl_bench;

    localparam int WARM = 12;
    localparam int HOLD = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mst = 1'b0, scl = 1'b0, mlv = 1'b0;
    logic p0 = 1'b0, p1 = 1'b0;
    logic en0 = 1'b1, sel0 = 1'b1, pdn0 = 1'b0, pdn1 = 1'b0;
    logic ref_oe, ref_sel, main_oe, shut, inhib;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    oscout_pwr_ctl #(.WARM_CYCLES(WARM), .PD_HOLD(HOLD)) u_oscout_pwr_ctl (
        .clk(clk), .rst(rst),
        .ref_master_i(mst), .ref_scaled_i(scl), .main_lvl_i(mlv),
        .pin0_i(p0), .pin1_i(p1),
        .cfg_en0_i(en0), .cfg_sel0_i(sel0), .cfg_pdn0_i(pdn0), .cfg_pdn1_i(pdn1),
        .ref_oe_o(ref_oe), .ref_sel_o(ref_sel), .main_oe_o(main_oe),
        .shutdown_o(shut), .prog_inhibit_o(inhib)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        chk("R1 oe0 in reset", ref_oe, 1'b0);
        chk("R1 oe1 in reset", main_oe, 1'b0);
        chk("R1 shut in reset", shut, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // Exhaustive sweep: config bits and both pins, clock levels low.
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 4; p++) begin
                bit e_ref, e_main, e_sel, e_pd, pd0, pd1;
                en0 = c[0]; sel0 = c[1]; pdn0 = c[2]; pdn1 = c[3];
                p0 = p[0]; p1 = p[1];
                mst = 0; scl = 0; mlv = 0;
                e_sel = sel0; e_ref = 1; pd0 = 0;
                if (pdn0) pd0 = p0;                      // R2
                else if (en0) e_ref = !p0;               // R3
                else if (sel0) e_sel = p0;               // R4
                else begin e_ref = 0; pd0 = p0; end      // R5
                pd1 = pdn1 & p1;
                e_main = pdn1 | !p1;                     // R6
                e_pd = pd0 | pd1;
                do_reset();
                step(1);
                chk("R1 warm quiet", ref_oe | main_oe, 1'b0);
                step(WARM + HOLD + 6);
                if (e_pd) begin
                    chk("R6 pd shutdown", shut, 1'b1);
                    chk("R12 inhibit on", inhib, 1'b1);
                    chk("R10 ref off", ref_oe, 1'b0);
                    chk("R10 main off", main_oe, 1'b0);
                end else begin
                    chk("R6 no shutdown", shut, 1'b0);
                    chk("R12 inhibit off", inhib, 1'b0);
                    chk("R3 ref enable", ref_oe, e_ref);
                    chk("R6 main enable", main_oe, e_main);
                    chk("R4 select", ref_sel, e_sel);
                end
            end
        end

        // R1: exact warm-up length, default config.
        en0 = 1; sel0 = 1; pdn0 = 0; pdn1 = 0; p0 = 0; p1 = 0;
        do_reset();
        step(WARM);
        chk("R1 off at WARM", ref_oe | main_oe, 1'b0);
        step(1);
        chk("R1 ref on at WARM+1", ref_oe, 1'b1);
        chk("R1 main on at WARM+1", main_oe, 1'b1);

        // R7: disable waits for low level (ref carries prescaled clock).
        scl = 1; p0 = 1;
        step(5);
        chk("R7 hold while high", ref_oe, 1'b1);
        scl = 0;
        step(1);
        chk("R7 drop when low", ref_oe, 1'b0);
        scl = 1; p0 = 0;
        step(4);
        chk("R7 stay off while high", ref_oe, 1'b0);
        scl = 0;
        step(1);
        chk("R7 re-enable when low", ref_oe, 1'b1);

        // R9: short power-down pulse has no effect.
        pdn1 = 1;
        p1 = 1;
        step(HOLD - 1);
        p1 = 0;
        step(6);
        chk("R9 short pulse shut", shut, 1'b0);
        chk("R9 short pulse main", main_oe, 1'b1);
        chk("R9 short pulse ref", ref_oe, 1'b1);

        // R10: drain waits for main output low before shutdown.
        mlv = 1;
        p1 = 1;
        step(HOLD + 2);
        chk("R10 ref drained", ref_oe, 1'b0);
        chk("R10 main held high", main_oe, 1'b1);
        step(6);
        chk("R10 no shutdown yet", shut, 1'b0);
        mlv = 0;
        step(1);
        chk("R10 main drained", main_oe, 1'b0);
        chk("R10 shut after drain", shut, 1'b0);
        step(1);
        chk("R10 shutdown", shut, 1'b1);
        chk("R12 inhibit", inhib, 1'b1);

        // R11: wake-up timing.
        p1 = 0;
        step(1);
        chk("R11 still down", shut, 1'b1);
        step(1);
        chk("R11 awake", shut, 1'b0);
        chk("R12 inhibit clear", inhib, 1'b0);
        step(WARM);
        chk("R11 warm off", ref_oe | main_oe, 1'b0);
        step(1);
        chk("R11 ref back", ref_oe, 1'b1);
        chk("R11 main back", main_oe, 1'b1);

        // R8: select moves only with both clocks low.
        en0 = 0; sel0 = 1; pdn0 = 0; pdn1 = 0; p0 = 0; p1 = 0;
        do_reset();
        step(WARM + 2);
        chk("R8 sel master", ref_sel, 1'b0);
        mst = 1; p0 = 1;
        step(3);
        chk("R8 sel held", ref_sel, 1'b0);
        mst = 0; scl = 1;
        step(3);
        chk("R8 sel held scaled high", ref_sel, 1'b0);
        scl = 0;
        step(1);
        chk("R8 sel moved", ref_sel, 1'b1);

        // R13: power-down qualifies on the last warm-up edge.
        en0 = 1; sel0 = 1; pdn0 = 0; pdn1 = 1; p0 = 0; p1 = 0;
        do_reset();
        step(WARM - HOLD - 1);
        p1 = 1;
        step(HOLD + 1);
        chk("R13 no enable", ref_oe | main_oe, 1'b0);
        chk("R13 not yet down", shut, 1'b0);
        step(1);
        chk("R13 shutdown", shut, 1'b1);
        chk("R13 still off", ref_oe | main_oe, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule